// File: doc/BRIEF.md
# SECDED Syndrome Bit Locator

This block checks and repairs 72-bit memory words made of 64 data bits and 8 check bits. The code has odd-weight columns: every data bit has a fixed, non-sequential 8-bit column pattern, and every check bit has a one-hot column. The block recomputes the check bits from the data half of an incoming word and XORs them with the stored check bits to form the syndrome. It then looks the syndrome up in the column table to find which bit failed.

A zero syndrome means the word is clean. A syndrome equal to a column flags a correctable single-bit error, and when the failing bit lies in the data half that bit is inverted in the output. Any other syndrome is reported as uncorrectable, and the data is passed through unchanged. Every even-weight nonzero syndrome falls in this last group, which covers all double-bit errors.

Results leave through a one-entry registered stage that uses a valid/ready handshake:
- A word is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- The result appears on the following edge.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result holds still and no new word is taken.

A combinational check-bit generator on the same table is brought out on separate pins for building stored words.

Top module: `ecc72_word_decoder`

## Requirements
- R1: `out_syndrome` bit b equals the XOR of two values. The first is the XOR of the data bits whose column has bit b set. The second is word bit 64+(7-b). A word built from `enc_check` and its data gives syndrome 0.
- R2: Data bit i has a fixed column for i in 0..63. Columns for bits 0..31 are F4 F1 EC EA E9 E6 E5 E3 DC DA D9 D6 D5 D3 CE CB B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A (hex). Columns for bits 32..63 are 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B. A syndrome equal to column i reports `out_index` = i.
- R3: Check bit k sits at word bit 64+k and has column 80 shifted right by k (hex). A syndrome equal to that column reports `out_index` = 64+k, and the output data is left unchanged.
- R4: A zero syndrome gives `out_class` = 0 (clean), `out_data` equal to word bits 63:0, and `out_index` = 72.
- R5: A nonzero syndrome that equals a column gives `out_class` = 1 (corrected). If the index is below 64, that data bit is inverted in `out_data`.
- R6: A nonzero syndrome that matches no column gives `out_class` = 2 (uncorrectable), `out_index` = 72 and unmodified data. This includes every even-weight syndrome. Class value 3 never appears.
- R7: `enc_check` bit k is the XOR of the data bits of `enc_data` whose column has bit 7-k set. It is combinational.
- R8: A word accepted on an edge makes `out_valid` high after that edge, with the result for that word.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R10: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 72 | Stored word: data in 63:0, check bits in 71:64 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Data after correction |
| out_class | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| out_index | output | 7 | Failing bit position 0..71, or 72 when none is located |
| out_syndrome | output | 8 | Computed syndrome |
| enc_data | input | 64 | Data to generate check bits for |
| enc_check | output | 8 | Check bits for `enc_data`, in word order |

## Verification
A directed sweep flips each of the 72 positions of an encoded word in turn. This shows that every column is located at its own index, and that only data positions alter the output data. Clean words, including all-zero and all-ones data, isolate the pass-through path. Double flips produce even syndromes, which must never be treated as correctable. Triple flips and arbitrary words produce odd syndromes that may or may not hit a column, which separates table lookup from a simple weight test. Random gaps on both `in_valid` and `out_ready` exercise the hold and refill timing of the output stage.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_FIXED = 2'd1,
    CLS_FATAL = 2'd2
  } err_class_e;

  // Columns of data bits 0..31
  function automatic logic [7:0] col_lower(int i);
    case (i)
      0:  return 8'hF4;  1:  return 8'hF1;  2:  return 8'hEC;  3:  return 8'hEA;
      4:  return 8'hE9;  5:  return 8'hE6;  6:  return 8'hE5;  7:  return 8'hE3;
      8:  return 8'hDC;  9:  return 8'hDA;  10: return 8'hD9;  11: return 8'hD6;
      12: return 8'hD5;  13: return 8'hD3;  14: return 8'hCE;  15: return 8'hCB;
      16: return 8'hB5;  17: return 8'hB0;  18: return 8'hAD;  19: return 8'hAB;
      20: return 8'hA8;  21: return 8'hA7;  22: return 8'hA4;  23: return 8'hA2;
      24: return 8'h9D;  25: return 8'h9B;  26: return 8'h98;  27: return 8'h97;
      28: return 8'h94;  29: return 8'h92;  30: return 8'h8F;  31: return 8'h8A;
      default: return 8'h00;
    endcase
  endfunction

  // Columns of data bits 32..63 (argument is offset from 32)
  function automatic logic [7:0] col_upper(int i);
    case (i)
      0:  return 8'h75;  1:  return 8'h70;  2:  return 8'h6D;  3:  return 8'h6B;
      4:  return 8'h68;  5:  return 8'h67;  6:  return 8'h64;  7:  return 8'h62;
      8:  return 8'h5E;  9:  return 8'h5B;  10: return 8'h58;  11: return 8'h57;
      12: return 8'h54;  13: return 8'h52;  14: return 8'h4F;  15: return 8'h4A;
      16: return 8'h34;  17: return 8'h31;  18: return 8'h2C;  19: return 8'h2A;
      20: return 8'h29;  21: return 8'h26;  22: return 8'h25;  23: return 8'h23;
      24: return 8'h1C;  25: return 8'h1A;  26: return 8'h19;  27: return 8'h16;
      28: return 8'h15;  29: return 8'h13;  30: return 8'h0E;  31: return 8'h0B;
      default: return 8'h00;
    endcase
  endfunction

  // Column of any word position; check bits are one-hot, highest first
  function automatic logic [7:0] column(int pos);
    if (pos < 32)          return col_lower(pos);
    else if (pos < DATA_W) return col_upper(pos - 32);
    else if (pos < WORD_W) return 8'h80 >> (pos - DATA_W);
    else                   return 8'h00;
  endfunction

  // Data bits that feed syndrome bit sb
  function automatic logic [DATA_W-1:0] feed_mask(int sb);
    logic [DATA_W-1:0] m;
    logic [7:0]        c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c    = column(i);
      m[i] = c[sb];
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc72_check_gen.sv
module ecc72_check_gen
  import ecc72_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);

  // check_o[k] is stored at word bit DW+k and covers syndrome bit CW-1-k
  for (genvar k = 0; k < CW; k++) begin : g_bit
    localparam int SB = CW - 1 - k;
    localparam logic [DW-1:0] MASK = feed_mask(SB);
    assign check_o[k] = ^(data_i & MASK);
  end

endmodule

// File: rtl/ecc72_syndrome.sv
module ecc72_syndrome
  import ecc72_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  localparam int WW = DW + CW
) (
  input  logic [WW-1:0] word_i,
  output logic [CW-1:0] syn_o
);

  logic [CW-1:0] regen;

  ecc72_check_gen #(.DW(DW), .CW(CW)) u_regen (
    .data_i  (word_i[DW-1:0]),
    .check_o (regen)
  );

  for (genvar b = 0; b < CW; b++) begin : g_syn
    assign syn_o[b] = regen[CW-1-b] ^ word_i[DW+CW-1-b];
  end

endmodule

// File: rtl/ecc72_locator.sv
module ecc72_locator
  import ecc72_pkg::*;
#(
  parameter int CW = CHK_W,
  parameter int WW = WORD_W,
  localparam int IW = $clog2(WW + 1)
) (
  input  logic [CW-1:0] syn_i,
  output logic [WW-1:0] hit_o,
  output logic [IW-1:0] index_o
);

  for (genvar p = 0; p < WW; p++) begin : g_cmp
    localparam logic [7:0] COL = column(p);
    assign hit_o[p] = (syn_i == COL[CW-1:0]);
  end

  always_comb begin
    index_o = IW'(WW);
    for (int p = WW - 1; p >= 0; p--) begin
      if (hit_o[p]) index_o = IW'(p);
    end
  end

  // Distinct columns: a syndrome names at most one position (R2, R3)
  always_comb begin
    assert_single_hit_R2: assert ($onehot0(hit_o))
      else $error("syndrome matched more than one column");
  end

endmodule

// File: rtl/ecc72_word_decoder.sv
module ecc72_word_decoder
  import ecc72_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  localparam int WW = DW + CW,
  localparam int IW = $clog2(WW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [WW-1:0] in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_class,
  output logic [IW-1:0] out_index,
  output logic [CW-1:0] out_syndrome,
  input  logic [DW-1:0] enc_data,
  output logic [CW-1:0] enc_check
);

  logic [CW-1:0] syn;
  logic [WW-1:0] hit;
  logic [IW-1:0] idx;
  err_class_e    cls;
  logic [DW-1:0] fixed_data;
  logic          take;

  ecc72_check_gen #(.DW(DW), .CW(CW)) u_enc (
    .data_i  (enc_data),
    .check_o (enc_check)
  );

  ecc72_syndrome #(.DW(DW), .CW(CW)) u_syn (
    .word_i (in_word),
    .syn_o  (syn)
  );

  ecc72_locator #(.CW(CW), .WW(WW)) u_loc (
    .syn_i   (syn),
    .hit_o   (hit),
    .index_o (idx)
  );

  always_comb begin
    if (syn == '0)   cls = CLS_CLEAN;
    else if (|hit)   cls = CLS_FIXED;
    else             cls = CLS_FATAL;
  end

  // Only data-half hits invert a bit; check-half hits leave data alone
  assign fixed_data = in_word[DW-1:0] ^ hit[DW-1:0];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_class    <= CLS_CLEAN;
      out_index    <= IW'(WW);
      out_syndrome <= '0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_data     <= fixed_data;
      out_class    <= cls;
      out_index    <= idx;
      out_syndrome <= syn;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid)
    else $error("accepted word produced no result");

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_class) && $stable(out_index) && $stable(out_syndrome)))
    else $error("stalled result changed");

  assert_clean_word_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_CLEAN) |-> (out_syndrome == '0 && out_index == IW'(WW)))
    else $error("clean class with nonzero syndrome or located index");

  assert_fixed_index_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == CLS_FIXED) |-> (out_index < IW'(WW) && out_syndrome != '0))
    else $error("corrected class without a located bit");

  assert_even_fatal_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_syndrome != '0 && !(^out_syndrome)) |-> (out_class == CLS_FATAL && out_index == IW'(WW)))
    else $error("even syndrome not flagged uncorrectable");

  assert_class_legal_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_class != 2'd3)
    else $error("illegal class code");

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !out_valid)
    else $error("result valid after reset");

endmodule

// File: tb/test_ecc72_word_decoder.sv
`timescale 1ns/1ps
module test_ecc72_word_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [71:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [1:0]  out_class;
  logic [6:0]  out_index;
  logic [7:0]  out_syndrome;
  logic [63:0] enc_data = '0;
  logic [7:0]  enc_check;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ecc72_word_decoder i_ecc72_word_decoder (
    .clk, .rst, .in_valid, .in_ready, .in_word, .out_valid, .out_ready,
    .out_data, .out_class, .out_index, .out_syndrome, .enc_data, .enc_check
  );

  localparam logic [7:0] TBL [64] = '{
    8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
    8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
    8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
    8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
    8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
    8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
    8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
    8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
  };

  // Reference model state: what the outputs should show now
  bit          m_valid = 1'b0;
  logic [63:0] m_data  = '0;
  int          m_class = 0;
  int          m_index = 72;
  logic [7:0]  m_syn   = '0;

  function automatic logic [7:0] ref_col(int p);
    if (p < 64) return TBL[p];
    return 8'h80 >> (p - 64);
  endfunction

  // Check bits in syndrome-bit order
  function automatic logic [7:0] ref_par(logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= TBL[i];
    return c;
  endfunction

  function automatic logic [7:0] ref_check(logic [63:0] d);   // word order (R7)
    logic [7:0] c = ref_par(d);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[k] = c[7-k];
    return w;
  endfunction

  function automatic logic [71:0] ref_encode(logic [63:0] d);
    return {ref_check(d), d};
  endfunction

  function automatic logic [7:0] ref_syn(logic [71:0] w);      // R1
    logic [7:0] st;
    for (int b = 0; b < 8; b++) st[b] = w[64 + 7 - b];
    return ref_par(w[63:0]) ^ st;
  endfunction

  task automatic model_load(logic [71:0] w);
    int idx = 72;
    logic [7:0] s = ref_syn(w);
    for (int p = 0; p < 72; p++) if (s != 8'h00 && ref_col(p) == s) idx = p;
    m_valid = 1'b1;
    m_syn   = s;
    m_index = idx;
    m_data  = w[63:0];
    if (s == 8'h00)   m_class = 0;
    else if (idx < 72) begin
      m_class = 1;
      if (idx < 64) m_data[idx] = ~m_data[idx];
    end else          m_class = 2;
  endtask

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    string rq;
    chk("R8 out_valid", 72'(out_valid), 72'(m_valid));
    chk("R9 in_ready", 72'(in_ready), 72'(!m_valid || out_ready));
    chk("R7 enc_check", 72'(enc_check), 72'(ref_check(enc_data)));
    if (m_valid) begin
      rq = (m_class == 0) ? "R4" : (m_class == 1) ? "R5" : "R6";
      chk("R1 syndrome", 72'(out_syndrome), 72'(m_syn));
      chk({rq, " class"}, 72'(out_class), 72'(m_class));
      if (m_index < 64)       chk("R2 index", 72'(out_index), 72'(m_index));
      else if (m_index < 72)  chk("R3 index", 72'(out_index), 72'(m_index));
      else                    chk({rq, " index"}, 72'(out_index), 72'(m_index));
      chk({rq, " data"}, 72'(out_data), 72'(m_data));
    end
  endtask

  // One cycle: check current outputs, then apply next inputs and advance model
  task automatic step(bit v, logic [71:0] w, bit rdy);
    @(negedge clk);
    compare();
    in_valid  = v;
    in_word   = w;
    out_ready = rdy;
    enc_data  = {$urandom, $urandom};
    if (v && (!m_valid || rdy)) model_load(w);
    else if (rdy)               m_valid = 1'b0;
  endtask

  function automatic logic [71:0] pick_word(int kind);
    logic [63:0] d = {$urandom, $urandom};
    logic [71:0] w = ref_encode(d);
    int p1 = $urandom % 72;
    int p2 = (p1 + 1 + ($urandom % 71)) % 72;
    int p3 = $urandom % 72;
    case (kind)
      0: return w;
      1: return w ^ (72'd1 << ($urandom % 64));
      2: return w ^ (72'd1 << (64 + ($urandom % 8)));
      3: return w ^ (72'd1 << p1) ^ (72'd1 << p2);
      4: return {$urandom, $urandom, $urandom};
      5: return ($urandom % 2) ? ref_encode('0) : ref_encode('1);
      default: begin
        while (p3 == p1 || p3 == p2) p3 = $urandom % 72;
        return w ^ (72'd1 << p1) ^ (72'd1 << p2) ^ (72'd1 << p3);
      end
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5EC0DE));
    // Reset phase (R10)
    repeat (3) begin
      @(negedge clk);
      chk("R10 out_valid in reset", 72'(out_valid), 72'd0);
    end
    rst = 1'b0;
    m_valid = 1'b0;

    // Every single position in turn (R2, R3, R5)
    for (int p = 0; p < 72; p++) step(1'b1, ref_encode(64'hA5C3_0F96_1E2D_B487) ^ (72'd1 << p), 1'b1);
    // Clean extremes (R4) and adjacent doubles (R6)
    step(1'b1, ref_encode('0), 1'b1);
    step(1'b1, ref_encode('1), 1'b1);
    step(1'b1, ref_encode('0) ^ 72'h3, 1'b1);
    step(1'b1, ref_encode('1) ^ (72'd3 << 63), 1'b1);
    step(1'b1, {8'h00, 64'h0} ^ (72'd3 << 70), 1'b1);
    // Stall with a waiting word, then drain (R9)
    step(1'b1, ref_encode(64'h1234) ^ 72'h10, 1'b0);
    step(1'b1, ref_encode(64'h5678), 1'b0);
    step(1'b1, ref_encode(64'h5678), 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);

    // Random traffic with gaps on both sides
    for (int n = 0; n < 3000; n++)
      step(($urandom % 5) != 0, pick_word($urandom % 7), ($urandom % 10) < 7);

    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    @(negedge clk);
    compare();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule